// File: doc/BRIEF.md
# UART Receiver with Per-Character Error Tags

This block turns an asynchronous serial line into bytes and queues them in a receive FIFO. Each FIFO entry holds a data byte together with three tags: break, framing error and parity error. Because the tags are stored with the character, the status seen at the output always describes the byte currently at the head of the queue. A pop moves on to the next byte and its own tags.

The line is sampled on an oversampling tick, nominally 16 per bit. A start bit counts only if the line is still low at the middle of the bit. The frame always has 8 data bits. Parity can be off, even or odd, and is chosen at run time.

A line held low for a whole frame produces exactly one break entry. A break flag then stays raised until the line returns to the mark level. When a character completes while the FIFO is full and nothing is being popped, that character is dropped. The FIFO keeps its contents, and a sticky overrun flag is raised. A status-read strobe clears the overrun flag.

Top module: `uart_rx_tagged`

## Requirements
- R1: After reset, `data_ready`, `overrun_flag` and `line_break` are 0. With the FIFO empty, `head_data` and the three head tag outputs read 0.
- R2: Bits are sampled once every OVS ticks, at mid-bit. The data bits arrive LSB first. A low pulse that ends before the middle of the start bit produces no character.
- R3: `data_ready` is 1 exactly when the FIFO holds at least one character. `head_data` shows the oldest character.
- R4: With `parity_en`=1, the parity bit is checked. `parity_odd`=1 selects odd parity and 0 selects even parity. A mismatch sets `head_parity_err` for that character only. With `parity_en`=0 there is no parity bit and the tag is 0.
- R5: A stop bit sampled low sets `head_frame_err` for that character. The receiver then looks for no new start bit until the line has been high.
- R6: A frame in which every sampled bit is 0, stop bit included, stores exactly one entry. That entry has data 0x00 and both `head_break` and `head_frame_err` set. `line_break` goes high with it and falls only after the line has returned high.
- R7: A character completing while the FIFO holds DEPTH entries and `read_strobe` is 0 is not stored. The FIFO contents are unchanged and `overrun_flag` becomes 1 one cycle later.
- R8: `status_read` clears `overrun_flag` on the next edge. If a new overrun occurs in the same cycle, the flag stays set.
- R9: `read_strobe` pops the head entry, and the next entry's byte and tags appear at the outputs on the next cycle. `read_strobe` on an empty FIFO has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sample_tick | input | 1 | Oversampling enable, OVS per bit time |
| rx_line | input | 1 | Serial receive line, idle high |
| parity_en | input | 1 | 1 = frame carries a parity bit |
| parity_odd | input | 1 | 1 = odd parity, 0 = even parity |
| read_strobe | input | 1 | Pop the head character |
| status_read | input | 1 | Clear the sticky overrun flag |
| head_data | output | 8 | Byte at the FIFO head (0 when empty) |
| head_break | output | 1 | Break tag of the head character |
| head_frame_err | output | 1 | Framing tag of the head character |
| head_parity_err | output | 1 | Parity tag of the head character |
| data_ready | output | 1 | FIFO not empty |
| overrun_flag | output | 1 | Sticky overrun indication |
| line_break | output | 1 | Break seen and line not yet back to mark |

## Verification
Two events can fall on the same clock edge: the overrun set from a character arriving at a full FIFO, and the clear from `status_read`. The bench provokes this by filling the FIFO and then holding `status_read` high for the whole of the next frame, so the clear request is present on the very edge where the overrun is raised. It judges the result by counting the sampled cycles in which `overrun_flag` is high: exactly one means the set won on that edge and the clear took effect on the following one. A further frame without `status_read` then confirms the flag latches, and a full drain confirms that the dropped characters never entered the FIFO.

// File: rtl/uart_rxt_pkg.sv
package uart_rxt_pkg;
   localparam int DATA_BITS = 8;

   typedef struct packed {
      logic                 brk;
      logic                 ferr;
      logic                 perr;
      logic [DATA_BITS-1:0] data;
   } rx_entry_t;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_START = 3'd1,
      ST_DATA  = 3'd2,
      ST_PAR   = 3'd3,
      ST_STOP  = 3'd4,
      ST_MARK  = 3'd5
   } rx_state_t;
endpackage

// File: rtl/rxt_line_sync.sv
module rxt_line_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);
   logic [STAGES-1:0] chain;

   generate
      if (STAGES < 1) begin : g_bad
         $error("rxt_line_sync: STAGES must be at least 1");
      end
      if (STAGES == 1) begin : g_one
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '1;
            else        chain <= din;
         end
      end else begin : g_many
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '1;
            else        chain <= {chain[STAGES-2:0], din};
         end
      end
   endgenerate

   assign dout = chain[STAGES-1];
endmodule

// File: rtl/rxt_bit_engine.sv
module rxt_bit_engine
   import uart_rxt_pkg::*;
#(
   parameter int OVS = 16
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      tick,
   input  logic      rx_s,
   input  logic      parity_en,
   input  logic      parity_odd,
   output logic      char_valid,
   output rx_entry_t char_entry,
   output logic      line_break
);
   localparam int PW      = $clog2(OVS);
   localparam int BW      = $clog2(DATA_BITS);
   localparam logic [PW-1:0] MID  = PW'(OVS/2 - 1);
   localparam logic [PW-1:0] LAST = PW'(OVS - 1);
   localparam logic [BW-1:0] TOPB = BW'(DATA_BITS - 1);

   rx_state_t            state;
   logic [PW-1:0]        phase;
   logic [BW-1:0]        bitn;
   logic [DATA_BITS-1:0] shreg;
   logic                 pbit;
   logic                 allz;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= ST_IDLE;
         phase      <= '0;
         bitn       <= '0;
         shreg      <= '0;
         pbit       <= 1'b0;
         allz       <= 1'b0;
         char_valid <= 1'b0;
         char_entry <= '0;
         line_break <= 1'b0;
      end else begin
         char_valid <= 1'b0;
         if (tick) begin
            case (state)
               ST_IDLE: begin
                  if (!rx_s) begin
                     state <= ST_START;
                     phase <= '0;
                  end
               end
               ST_START: begin
                  if (phase == MID) begin
                     phase <= '0;
                     bitn  <= '0;
                     allz  <= 1'b1;
                     state <= rx_s ? ST_IDLE : ST_DATA;
                  end else begin
                     phase <= phase + 1'b1;
                  end
               end
               ST_DATA: begin
                  if (phase == LAST) begin
                     phase <= '0;
                     shreg <= {rx_s, shreg[DATA_BITS-1:1]};
                     allz  <= allz & ~rx_s;
                     bitn  <= bitn + 1'b1;
                     if (bitn == TOPB) state <= parity_en ? ST_PAR : ST_STOP;
                  end else begin
                     phase <= phase + 1'b1;
                  end
               end
               ST_PAR: begin
                  if (phase == LAST) begin
                     phase <= '0;
                     pbit  <= rx_s;
                     allz  <= allz & ~rx_s;
                     state <= ST_STOP;
                  end else begin
                     phase <= phase + 1'b1;
                  end
               end
               ST_STOP: begin
                  if (phase == LAST) begin
                     phase           <= '0;
                     char_valid      <= 1'b1;
                     char_entry.data <= shreg;
                     char_entry.perr <= parity_en & (^shreg ^ pbit ^ parity_odd);
                     char_entry.ferr <= ~rx_s;
                     char_entry.brk  <= allz & ~rx_s;
                     if (!rx_s) begin
                        state      <= ST_MARK;
                        line_break <= allz;
                     end else begin
                        state <= ST_IDLE;
                     end
                  end else begin
                     phase <= phase + 1'b1;
                  end
               end
               ST_MARK: begin
                  if (rx_s) begin
                     state      <= ST_IDLE;
                     line_break <= 1'b0;
                  end
               end
               default: state <= ST_IDLE;
            endcase
         end
      end
   end

   // R6
   break_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (char_valid && char_entry.brk) |-> (char_entry.data == '0 && char_entry.ferr))
      else $error("break entry carries data or lacks framing tag");

   // R6
   break_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(line_break) |-> $past(rx_s))
      else $error("line_break dropped while line low");

   // R2
   start_mid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_DATA && $past(state) == ST_START) |-> !$past(rx_s))
      else $error("start accepted with line high at mid-bit");

   // R5
   mark_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(state) == ST_MARK && state != ST_MARK) |-> $past(rx_s))
      else $error("left mark wait with line low");
endmodule

// File: rtl/rxt_fifo.sv
module rxt_fifo
   import uart_rxt_pkg::*;
#(
   parameter int DEPTH = 32
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      push,
   input  rx_entry_t wr_entry,
   input  logic      pop,
   output rx_entry_t head,
   output logic      empty,
   output logic      full
);
   localparam int CW = $clog2(DEPTH + 1);

   logic [CW-1:0] count;
   logic          do_pop;
   logic          do_push;

   assign empty   = (count == '0);
   assign full    = (count == CW'(DEPTH));
   assign do_pop  = pop && !empty;
   assign do_push = push && (!full || do_pop);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  count <= '0;
      else if (do_push && !do_pop) count <= count + 1'b1;
      else if (do_pop && !do_push) count <= count - 1'b1;
   end

   generate
      if (DEPTH < 1) begin : g_bad_depth
         $error("rxt_fifo: DEPTH must be at least 1");
      end
      if (DEPTH == 1) begin : g_hold
         rx_entry_t slot;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       slot <= '0;
            else if (do_push) slot <= wr_entry;
         end
         assign head = slot;
      end else begin : g_ring
         localparam int AW = $clog2(DEPTH);
         if ((1 << AW) != DEPTH) begin : g_bad_pow
            $error("rxt_fifo: DEPTH must be a power of two");
         end
         rx_entry_t     mem [DEPTH];
         logic [AW-1:0] wr_ptr;
         logic [AW-1:0] rd_ptr;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               wr_ptr <= '0;
               rd_ptr <= '0;
            end else begin
               if (do_push) wr_ptr <= wr_ptr + 1'b1;
               if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
            end
         end
         always_ff @(posedge clk) begin
            if (do_push) mem[wr_ptr] <= wr_entry;
         end
         assign head = mem[rd_ptr];
      end
   endgenerate

   // R7
   count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CW'(DEPTH))
      else $error("FIFO count above depth");

   // R9
   empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (empty && pop && !push) |=> empty)
      else $error("pop of empty FIFO changed its state");
endmodule

// File: rtl/uart_rx_tagged.sv
module uart_rx_tagged
   import uart_rxt_pkg::*;
#(
   parameter int OVS         = 16,
   parameter int FIFO_DEPTH  = 32,
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       sample_tick,
   input  logic       rx_line,
   input  logic       parity_en,
   input  logic       parity_odd,
   input  logic       read_strobe,
   input  logic       status_read,
   output logic [7:0] head_data,
   output logic       head_break,
   output logic       head_frame_err,
   output logic       head_parity_err,
   output logic       data_ready,
   output logic       overrun_flag,
   output logic       line_break
);
   generate
      if (OVS < 4 || (OVS % 2) != 0) begin : g_bad_ovs
         $error("uart_rx_tagged: OVS must be even and at least 4");
      end
   endgenerate

   logic      rx_s;
   logic      char_valid;
   rx_entry_t char_entry;
   rx_entry_t head;
   logic      fifo_empty;
   logic      fifo_full;
   logic      ovr_event;

   rxt_line_sync #(.STAGES(SYNC_STAGES)) sync_i (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (rx_line),
      .dout (rx_s)
   );

   rxt_bit_engine #(.OVS(OVS)) eng_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (sample_tick),
      .rx_s      (rx_s),
      .parity_en (parity_en),
      .parity_odd(parity_odd),
      .char_valid(char_valid),
      .char_entry(char_entry),
      .line_break(line_break)
   );

   rxt_fifo #(.DEPTH(FIFO_DEPTH)) fifo_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .push    (char_valid),
      .wr_entry(char_entry),
      .pop     (read_strobe),
      .head    (head),
      .empty   (fifo_empty),
      .full    (fifo_full)
   );

   assign ovr_event = char_valid && fifo_full && !read_strobe;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           overrun_flag <= 1'b0;
      else if (ovr_event)   overrun_flag <= 1'b1;
      else if (status_read) overrun_flag <= 1'b0;
   end

   assign data_ready      = !fifo_empty;
   assign head_data       = fifo_empty ? 8'h00 : head.data;
   assign head_break      = !fifo_empty && head.brk;
   assign head_frame_err  = !fifo_empty && head.ferr;
   assign head_parity_err = !fifo_empty && head.perr;

   // R7
   ovr_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(overrun_flag) |-> $past(char_valid && fifo_full))
      else $error("overrun raised without a character at a full FIFO");

   // R7
   fifo_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (char_valid && fifo_full && !read_strobe) |=> fifo_full)
      else $error("FIFO changed on overrun");

   // R8
   ovr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (status_read && !(char_valid && fifo_full && !read_strobe)) |=> !overrun_flag)
      else $error("overrun not cleared by status read");

   // R3
   ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (char_valid && !fifo_full) |=> data_ready)
      else $error("stored character not reported ready");
endmodule

// File: tb/uart_rx_tagged_tb_top.sv
module uart_rx_tagged_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int OVS        = 16;
   localparam int DEPTH      = 32;
   localparam int WDOG       = 100000;
   localparam int NVEC       = 7;

   // {data[13:6], pen[5], podd[4], badpar[3], stop[2], exp_perr[1], exp_ferr[0]}
   localparam logic [13:0] VEC [NVEC] = '{
      {8'hA5, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0},
      {8'h3C, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0},
      {8'h3C, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0},
      {8'h81, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0},
      {8'h7E, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0},
      {8'h55, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1},
      {8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0}
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sample_tick = 1'b1;
   logic       rx_line = 1'b1;
   logic       parity_en = 1'b0;
   logic       parity_odd = 1'b0;
   logic       read_strobe = 1'b0;
   logic       status_read = 1'b0;
   logic [7:0] head_data;
   logic       head_break, head_frame_err, head_parity_err;
   logic       data_ready, overrun_flag, line_break;

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   int ovr_hi = 0;
   logic count_ovr = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   uart_rx_tagged #(.OVS(OVS), .FIFO_DEPTH(DEPTH)) dut_i (
      .clk(clk), .rst_n(rst_n), .sample_tick(sample_tick), .rx_line(rx_line),
      .parity_en(parity_en), .parity_odd(parity_odd),
      .read_strobe(read_strobe), .status_read(status_read),
      .head_data(head_data), .head_break(head_break),
      .head_frame_err(head_frame_err), .head_parity_err(head_parity_err),
      .data_ready(data_ready), .overrun_flag(overrun_flag), .line_break(line_break)
   );

   always @(negedge clk) begin
      cycles <= cycles + 1;
      if (count_ovr && overrun_flag) ovr_hi <= ovr_hi + 1;
      if (cycles > WDOG) begin
         errors = errors + 1;
         $display("FAIL watchdog: run exceeded %0d cycles (actual %0d, expected less)", WDOG, cycles);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks = checks + 1;
      if (act !== exp) begin
         errors = errors + 1;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic send_bit(input logic b);
      rx_line = b;
      idle(OVS);
   endtask

   task automatic send_frame(input logic [7:0] d, input logic pen, input logic podd,
                             input logic bad, input logic stop);
      parity_en  = pen;
      parity_odd = podd;
      send_bit(1'b0);
      for (int i = 0; i < 8; i++) send_bit(d[i]);
      if (pen) send_bit(^d ^ podd ^ bad);
      send_bit(stop);
      rx_line = 1'b1;
      idle(2 * OVS);
   endtask

   task automatic pop_one();
      read_strobe = 1'b1;
      @(negedge clk);
      read_strobe = 1'b0;
   endtask

   initial begin
      idle(3);
      rst_n = 1'b1;
      idle(2);
      // R1 reset state
      chk("R1 data_ready", data_ready, 0);
      chk("R1 overrun", overrun_flag, 0);
      chk("R1 line_break", line_break, 0);
      chk("R1 head outputs", {head_data, head_break, head_frame_err, head_parity_err}, 0);

      // R9 pop on empty has no effect
      pop_one();
      chk("R9 empty pop", data_ready, 0);

      // R2 short glitch rejected
      rx_line = 1'b0;
      idle(4);
      rx_line = 1'b1;
      idle(3 * OVS);
      chk("R2 glitch", data_ready, 0);

      // Table: queue all vectors, then drain checking each entry's tags
      for (int v = 0; v < NVEC; v++)
         send_frame(VEC[v][13:6], VEC[v][5], VEC[v][4], VEC[v][3], VEC[v][2]);
      chk("R3 ready after table", data_ready, 1);
      for (int v = 0; v < NVEC; v++) begin
         chk("R2 R3 head data", head_data, VEC[v][13:6]);
         chk("R4 parity tag", head_parity_err, VEC[v][1]);
         chk("R5 framing tag", head_frame_err, VEC[v][0]);
         chk("R6 no break tag", head_break, 0);
         pop_one();
      end
      chk("R9 drained", data_ready, 0);

      // R7 R8: fill, then overrun while status_read held
      for (int i = 0; i < DEPTH; i++) send_frame(8'(i * 7 + 1), 1'b0, 1'b0, 1'b0, 1'b1);
      chk("R7 head before overrun", head_data, 8'h01);
      status_read = 1'b1;
      count_ovr   = 1'b1;
      send_frame(8'hEE, 1'b0, 1'b0, 1'b0, 1'b1);
      count_ovr   = 1'b0;
      status_read = 1'b0;
      chk("R8 set wins over clear", ovr_hi, 1);
      chk("R8 cleared after", overrun_flag, 0);
      send_frame(8'hDD, 1'b0, 1'b0, 1'b0, 1'b1);
      chk("R7 overrun latched", overrun_flag, 1);
      chk("R7 head intact", head_data, 8'h01);
      status_read = 1'b1;
      @(negedge clk);
      status_read = 1'b0;
      chk("R8 status read clears", overrun_flag, 0);
      begin
         int bad = 0;
         for (int i = 0; i < DEPTH; i++) begin
            if (head_data !== 8'(i * 7 + 1) || data_ready !== 1'b1) bad++;
            pop_one();
         end
         chk("R7 contents intact", bad, 0);
      end
      chk("R7 nothing extra stored", data_ready, 0);

      // R6 break: line low for three frame times
      parity_en = 1'b0;
      rx_line = 1'b0;
      idle(3 * 10 * OVS);
      chk("R6 break entry", {head_data, head_break, head_frame_err}, {8'h00, 1'b1, 1'b1});
      chk("R6 line_break held", line_break, 1);
      rx_line = 1'b1;
      idle(2 * OVS);
      chk("R6 line_break released", line_break, 0);
      pop_one();
      chk("R6 single entry", data_ready, 0);

      // R5 receiver resumes after line goes high
      send_frame(8'h5A, 1'b0, 1'b0, 1'b0, 1'b1);
      chk("R5 resume after mark", {head_data, head_frame_err}, {8'h5A, 1'b0});

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule